// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the write side of a NOR-style parallel flash port. It watches each bus write (a strobe, a word offset and a data byte) and follows the multi-write command protocol. A command is accepted only after a two-write unlock pattern has arrived at the two configured offsets. It then decodes the command byte and raises a one-cycle request for a word program, a sector erase or a whole-chip erase. Any write that does not fit the expected step aborts the sequence and returns the block to read-array mode.

The two unlock offsets are run-time inputs, not constants. Every offset check uses the values present on those inputs when the write is taken. A typical setting is 0x555 and 0x2AA. The outputs show the command currently in progress, a query-mode flag and a bypass-mode flag. A program or erase request carries the offset and data of the write that completed it.

The write port has no back-pressure. A write is taken on every rising clock edge where `wr_en` is high. The result appears on the outputs in the following cycle.

Top module: `flash_cmd_seq`

## Requirements
- R1: On synchronous active-high reset, `cur_cmd` is 0x00 (read-array), `query_mode` and `bypass_mode` are 0, and all request pulses are 0.
- R2: Outside bypass and query mode, the first write of a sequence must be 0xAA at `unlock_off0`. Any other write aborts: `cur_cmd` becomes 0x00 and the next write is treated as a first write.
- R3: The second write must be 0x55 at `unlock_off1`. Any other write aborts to read-array.
- R4: The third write must be at `unlock_off0`. Its data selects the command: 0xA0 sets `cur_cmd` to 0xA0, 0x80 sets `cur_cmd` to 0x80, and 0x20 enters bypass. Any other offset or data aborts to read-array.
- R5: While `cur_cmd` is 0xA0, the next write produces a one-cycle `prog_pulse`, with `op_offset` and `op_data` equal to that write's offset and data. `cur_cmd` then returns to 0x00.
- R6: After 0x80, the erase sequence needs 0xAA at `unlock_off0` and then 0x55 at `unlock_off1`, after which the final write arrives. A final write of 0x30 at any offset gives a one-cycle `sect_erase_pulse` with `op_offset` equal to that offset.
- R7: A final write of 0x10 gives `chip_erase_pulse` only when its offset equals `unlock_off0`. At any other offset, no pulse is issued and the block aborts to read-array.
- R8: A write of 0x98 while idle sets `query_mode` and sets `cur_cmd` to 0x98. While in query mode, every write other than 0xF0 is ignored.
- R9: A write of 0xF0 in any state sets `cur_cmd` to 0x00, clears `query_mode` and restarts the sequence. It leaves `bypass_mode` unchanged.
- R10: In bypass mode, an idle write is taken as the command write, with no unlock writes and no offset check. 0xA0 arms a program. 0x90 followed by 0x00 clears `bypass_mode`. Any other write aborts, and bypass stays set.
- R11: Changing `unlock_off0` and `unlock_off1` moves all unlock and chip-erase offset checks to the new values.
- R12: At most one request pulse is high in any cycle, and no pulse stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_offset | input | 16 | Word offset of the write |
| wr_data | input | 8 | Data byte of the write |
| unlock_off0 | input | 16 | First unlock offset, also the command and chip-erase offset |
| unlock_off1 | input | 16 | Second unlock offset |
| cur_cmd | output | 8 | Command in progress, 0x00 for read-array |
| query_mode | output | 1 | Query mode is active |
| bypass_mode | output | 1 | Unlock bypass is active |
| prog_pulse | output | 1 | One-cycle word program request |
| sect_erase_pulse | output | 1 | One-cycle sector erase request |
| chip_erase_pulse | output | 1 | One-cycle chip erase request |
| op_offset | output | 16 | Offset that goes with the current request |
| op_data | output | 8 | Data that goes with the current request |

## Verification
The reset command 0xF0 and a request pulse can fall in the same cycle: a pulse issued by the previous write is still high while an 0xF0 write is being taken. The random stream places 0xF0 and erase or program completions back to back, and the directed part does the same on purpose. For every cycle, the bench model predicts the pulse from the previous write and the state from the 0xF0, and both are checked in that one cycle. A second coincidence is the chip-erase code arriving at the wrong offset. The bench judges this by checking that no chip-erase pulse appears and that the block returns to read-array.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_CMD, ST_PROG, ST_ER0, ST_ER1, ST_ERF, ST_BEXIT
  } seq_state_t;

  localparam logic [7:0] CODE_UNL0   = 8'hAA;
  localparam logic [7:0] CODE_UNL1   = 8'h55;
  localparam logic [7:0] CODE_PROG   = 8'hA0;
  localparam logic [7:0] CODE_ERASE  = 8'h80;
  localparam logic [7:0] CODE_BYP    = 8'h20;
  localparam logic [7:0] CODE_CHIP   = 8'h10;
  localparam logic [7:0] CODE_SECT   = 8'h30;
  localparam logic [7:0] CODE_QUERY  = 8'h98;
  localparam logic [7:0] CODE_RESET  = 8'hF0;
  localparam logic [7:0] CODE_BEXIT  = 8'h90;
  localparam logic [7:0] CODE_BEXIT2 = 8'h00;
  localparam logic [7:0] CODE_READ   = 8'h00;

  localparam int OP_PROG = 0;
  localparam int OP_SECT = 1;
  localparam int OP_CHIP = 2;
  localparam int OP_N    = 3;
endpackage

// File: rtl/flash_seq_match.sv
module flash_seq_match #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] off0,
  input  logic [ADDR_W-1:0] off1,
  output logic              at_off0,
  output logic              hit0,
  output logic              hit1
);
  import flash_seq_pkg::*;
  logic at_off1;
  always_comb begin
    at_off0 = (offset == off0);
    at_off1 = (offset == off1);
    hit0    = at_off0 && (data == CODE_UNL0);
    hit1    = at_off1 && (data == CODE_UNL1);
  end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm #(
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [DATA_W-1:0]             data,
  input  logic                          at_off0,
  input  logic                          hit0,
  input  logic                          hit1,
  output logic [DATA_W-1:0]             cmd,
  output logic                          query,
  output logic                          bypass,
  output logic [flash_seq_pkg::OP_N-1:0] req
);
  import flash_seq_pkg::*;

  seq_state_t        st, st_n;
  logic [DATA_W-1:0] cmd_n;
  logic              q_n, byp_n;

  always_comb begin
    st_n  = st;
    cmd_n = cmd;
    q_n   = query;
    byp_n = bypass;
    req   = '0;
    if (wr_en) begin
      if (data == CODE_RESET) begin
        st_n  = ST_IDLE;
        cmd_n = CODE_READ;
        q_n   = 1'b0;
      end else if (!query) begin
        st_n  = ST_IDLE;
        cmd_n = CODE_READ;
        unique case (st)
          ST_IDLE: begin
            if (data == CODE_QUERY) begin
              q_n   = 1'b1;
              cmd_n = CODE_QUERY;
            end else if (bypass) begin
              if (data == CODE_PROG) begin
                st_n  = ST_PROG;
                cmd_n = CODE_PROG;
              end else if (data == CODE_BEXIT) begin
                st_n  = ST_BEXIT;
                cmd_n = CODE_BEXIT;
              end
            end else if (hit0) begin
              st_n = ST_UNL1;
            end
          end
          ST_UNL1: if (hit1) st_n = ST_CMD;
          ST_CMD: begin
            if (at_off0) begin
              if (data == CODE_PROG) begin
                st_n  = ST_PROG;
                cmd_n = CODE_PROG;
              end else if (data == CODE_ERASE) begin
                st_n  = ST_ER0;
                cmd_n = CODE_ERASE;
              end else if (data == CODE_BYP) begin
                byp_n = 1'b1;
              end
            end
          end
          ST_PROG: req[OP_PROG] = 1'b1;
          ST_ER0: if (hit0) begin
            st_n  = ST_ER1;
            cmd_n = cmd;
          end
          ST_ER1: if (hit1) begin
            st_n  = ST_ERF;
            cmd_n = cmd;
          end
          ST_ERF: begin
            if (data == CODE_SECT) req[OP_SECT] = 1'b1;
            else if (data == CODE_CHIP && at_off0) req[OP_CHIP] = 1'b1;
          end
          ST_BEXIT: if (data == CODE_BEXIT2) byp_n = 1'b0;
          default: st_n = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cmd    <= CODE_READ;
      query  <= 1'b0;
      bypass <= 1'b0;
    end else begin
      st     <= st_n;
      cmd    <= cmd_n;
      query  <= q_n;
      bypass <= byp_n;
    end
  end

  // R9: reset command always lands in idle read-array with query cleared
  assert_reset_cmd_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && data == CODE_RESET) |=> (st == ST_IDLE && !query && cmd == CODE_READ));

  // R8: query mode only entered by the query code
  assert_query_entry_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(query) |-> ($past(wr_en) && $past(data) == CODE_QUERY));

  // R8: other writes ignored while in query mode
  assert_query_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (query && wr_en && data != CODE_RESET) |=> (query && $stable(cmd)));

  // R10: bypass leaves only after the exit prefix
  assert_bypass_exit_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(bypass) |-> ($past(st) == ST_BEXIT && $past(data) == CODE_BEXIT2));
endmodule

// File: rtl/flash_seq_issue.sv
module flash_seq_issue #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [flash_seq_pkg::OP_N-1:0] req,
  input  logic [ADDR_W-1:0]             offset,
  input  logic [DATA_W-1:0]             data,
  input  logic [ADDR_W-1:0]             off0,
  output logic [flash_seq_pkg::OP_N-1:0] pulse,
  output logic [ADDR_W-1:0]             op_offset,
  output logic [DATA_W-1:0]             op_data
);
  import flash_seq_pkg::*;

  for (genvar g = 0; g < OP_N; g++) begin : g_pulse
    always_ff @(posedge clk) begin
      if (rst) pulse[g] <= 1'b0;
      else     pulse[g] <= req[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_offset <= '0;
      op_data   <= '0;
    end else if (|req) begin
      op_offset <= offset;
      op_data   <= data;
    end
  end

  assert_pulse_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulse));

  assert_pulse_single_R12: assert property (@(posedge clk) disable iff (rst)
    (|pulse) |=> !(|pulse));

  // R7: chip erase only at the first unlock offset
  assert_chip_offset_R7: assert property (@(posedge clk) disable iff (rst)
    pulse[OP_CHIP] |-> ($past(offset) == $past(off0) && $past(data) == CODE_CHIP));

  // R5: program pulse carries the completing write
  assert_prog_payload_R5: assert property (@(posedge clk) disable iff (rst)
    pulse[OP_PROG] |-> (op_offset == $past(offset) && op_data == $past(data)));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_offset,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] unlock_off0,
  input  logic [ADDR_W-1:0] unlock_off1,
  output logic [DATA_W-1:0] cur_cmd,
  output logic              query_mode,
  output logic              bypass_mode,
  output logic              prog_pulse,
  output logic              sect_erase_pulse,
  output logic              chip_erase_pulse,
  output logic [ADDR_W-1:0] op_offset,
  output logic [DATA_W-1:0] op_data
);
  import flash_seq_pkg::*;

  logic            at_off0, hit0, hit1;
  logic [OP_N-1:0] req, pulse;

  flash_seq_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .offset(wr_offset), .data(wr_data), .off0(unlock_off0), .off1(unlock_off1),
    .at_off0(at_off0), .hit0(hit0), .hit1(hit1));

  flash_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .data(wr_data),
    .at_off0(at_off0), .hit0(hit0), .hit1(hit1),
    .cmd(cur_cmd), .query(query_mode), .bypass(bypass_mode), .req(req));

  flash_seq_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
    .clk(clk), .rst(rst), .req(req), .offset(wr_offset), .data(wr_data),
    .off0(unlock_off0), .pulse(pulse), .op_offset(op_offset), .op_data(op_data));

  assign prog_pulse       = pulse[OP_PROG];
  assign sect_erase_pulse = pulse[OP_SECT];
  assign chip_erase_pulse = pulse[OP_CHIP];
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_offset = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] off0 = 16'h0555;
  logic [15:0] off1 = 16'h02AA;
  logic [7:0]  cur_cmd, op_data;
  logic [15:0] op_offset;
  logic        query_mode, bypass_mode, prog_pulse, sect_erase_pulse, chip_erase_pulse;

  always #4 clk = ~clk;

  flash_cmd_seq u_flash_cmd_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_offset(wr_offset), .wr_data(wr_data),
    .unlock_off0(off0), .unlock_off1(off1), .cur_cmd(cur_cmd),
    .query_mode(query_mode), .bypass_mode(bypass_mode), .prog_pulse(prog_pulse),
    .sect_erase_pulse(sect_erase_pulse), .chip_erase_pulse(chip_erase_pulse),
    .op_offset(op_offset), .op_data(op_data));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model: 0 idle,1 unl1,2 cmd,3 prog,4 er0,5 er1,6 final,7 bypass exit
  int         m_st = 0;
  logic [7:0] m_cmd = 8'h00;
  bit         m_q = 0, m_byp = 0;
  bit [2:0]   m_pulse = 0;
  logic [15:0] m_off = '0;
  logic [7:0]  m_dat = '0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step(bit we, logic [15:0] off, logic [7:0] d);
    int ps;
    m_pulse = 3'b000;
    if (!we) return;
    if (d == 8'hF0) begin m_st = 0; m_cmd = 8'h00; m_q = 0; return; end
    if (m_q) return;
    ps = m_st;
    m_st = 0;
    m_cmd = 8'h00;
    case (ps)
      0: if (d == 8'h98) begin m_q = 1; m_cmd = 8'h98; end
         else if (m_byp) begin
           if (d == 8'hA0) begin m_st = 3; m_cmd = 8'hA0; end
           else if (d == 8'h90) begin m_st = 7; m_cmd = 8'h90; end
         end else if (off == off0 && d == 8'hAA) m_st = 1;
      1: if (off == off1 && d == 8'h55) m_st = 2;
      2: if (off == off0) begin
           if (d == 8'hA0) begin m_st = 3; m_cmd = 8'hA0; end
           else if (d == 8'h80) begin m_st = 4; m_cmd = 8'h80; end
           else if (d == 8'h20) m_byp = 1;
         end
      3: begin m_pulse[0] = 1; m_off = off; m_dat = d; end
      4: if (off == off0 && d == 8'hAA) begin m_st = 5; m_cmd = 8'h80; end
      5: if (off == off1 && d == 8'h55) begin m_st = 6; m_cmd = 8'h80; end
      6: if (d == 8'h30) begin m_pulse[1] = 1; m_off = off; m_dat = d; end
         else if (d == 8'h10 && off == off0) begin m_pulse[2] = 1; m_off = off; m_dat = d; end
      7: if (d == 8'h00) m_byp = 0;
      default: m_st = 0;
    endcase
  endtask

  task automatic compare_all();
    chk("R4", "cur_cmd", cur_cmd, m_cmd);
    chk("R8", "query_mode", query_mode, m_q);
    chk("R10", "bypass_mode", bypass_mode, m_byp);
    chk("R12", "prog_pulse", prog_pulse, m_pulse[0]);
    chk("R6", "sect_erase_pulse", sect_erase_pulse, m_pulse[1]);
    chk("R7", "chip_erase_pulse", chip_erase_pulse, m_pulse[2]);
    if (m_pulse != 0) begin
      chk("R5", "op_offset", op_offset, m_off);
      chk("R5", "op_data", op_data, m_dat);
    end
  endtask

  task automatic cyc(bit we, logic [15:0] off, logic [7:0] d);
    @(negedge clk);
    wr_en = we; wr_offset = off; wr_data = d;
    @(posedge clk);
    model_step(we, off, d);
    #2;
    compare_all();
  endtask

  task automatic unlock2();
    cyc(1, off0, 8'hAA);
    cyc(1, off1, 8'h55);
  endtask

  function automatic logic [7:0] pick_data(int sel);
    case (sel)
      0: return 8'hAA;  1: return 8'h55;  2: return 8'hA0;  3: return 8'h80;
      4: return 8'h20;  5: return 8'h10;  6: return 8'h30;  7: return 8'h98;
      8: return 8'h90;  9: return 8'h00;  10: return 8'hF0;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "cur_cmd reset", cur_cmd, 8'h00);
    chk("R1", "query reset", query_mode, 0);
    chk("R1", "bypass reset", bypass_mode, 0);
    chk("R1", "pulses reset", {prog_pulse, sect_erase_pulse, chip_erase_pulse}, 0);
    @(negedge clk);
    rst = 1'b0;

    // R5 program
    unlock2();
    cyc(1, off0, 8'hA0);
    chk("R5", "armed cmd", cur_cmd, 8'hA0);
    cyc(1, 16'h1234, 8'h5A);
    chk("R5", "prog pulse", prog_pulse, 1);
    cyc(0, 0, 0);
    chk("R12", "prog pulse one cycle", prog_pulse, 0);
    // R2 bad first write
    cyc(1, off1, 8'hAA);
    cyc(1, off1, 8'h55);
    cyc(1, off0, 8'hA0);
    chk("R2", "abort after bad unlock0", cur_cmd, 8'h00);
    // R3 bad second write
    cyc(1, off0, 8'hAA);
    cyc(1, off1, 8'h56);
    cyc(1, off0, 8'hA0);
    chk("R3", "abort after bad unlock1", cur_cmd, 8'h00);
    // R4 command at wrong offset
    unlock2();
    cyc(1, off1, 8'hA0);
    chk("R4", "cmd wrong offset", cur_cmd, 8'h00);
    // R6 sector erase
    unlock2(); cyc(1, off0, 8'h80); unlock2();
    cyc(1, 16'h7000, 8'h30);
    chk("R6", "sector pulse", sect_erase_pulse, 1);
    chk("R6", "sector offset", op_offset, 16'h7000);
    // R7 chip erase wrong offset, then right, pulse meets F0 in same cycle
    unlock2(); cyc(1, off0, 8'h80); unlock2();
    cyc(1, off1, 8'h10);
    chk("R7", "no chip pulse off-target", chip_erase_pulse, 0);
    unlock2(); cyc(1, off0, 8'h80); unlock2();
    cyc(1, off0, 8'h10);
    chk("R7", "chip pulse", chip_erase_pulse, 1);
    cyc(1, 16'h0001, 8'hF0);
    chk("R9", "F0 with pulse tail", cur_cmd, 8'h00);
    // R8 query
    cyc(1, 16'h0055, 8'h98);
    chk("R8", "query on", query_mode, 1);
    cyc(1, off0, 8'hAA);
    chk("R8", "query ignores", cur_cmd, 8'h98);
    cyc(1, 16'h0, 8'hF0);
    chk("R9", "query cleared", query_mode, 0);
    // R10 bypass
    unlock2(); cyc(1, off0, 8'h20);
    chk("R10", "bypass on", bypass_mode, 1);
    cyc(1, 16'h0BAD, 8'hA0);
    cyc(1, 16'h0222, 8'h11);
    chk("R10", "bypass program", prog_pulse, 1);
    cyc(1, 16'h0, 8'hF0);
    chk("R9", "F0 keeps bypass", bypass_mode, 1);
    cyc(1, 16'h9, 8'h90); cyc(1, 16'h9, 8'h00);
    chk("R10", "bypass off", bypass_mode, 0);
    // R11 moved offsets
    off0 = 16'h0AAA; off1 = 16'h0555;
    unlock2(); cyc(1, off0, 8'hA0);
    chk("R11", "new offsets accepted", cur_cmd, 8'hA0);
    cyc(1, 16'h3, 8'h3);
    cyc(1, 16'h0555, 8'hAA);
    cyc(1, 16'h02AA, 8'h55);
    cyc(1, 16'h0555, 8'hA0);
    chk("R11", "old offsets rejected", cur_cmd, 8'h00);

    // random
    void'($urandom(32'd7));
    for (int i = 0; i < 4000; i++) begin
      int os;
      logic [15:0] o;
      if (i == 2000) begin off0 = 16'h0555; off1 = 16'h02AA; end
      os = int'($urandom % 4);
      o = (os == 0) ? off0 : (os == 1) ? off1 : (os == 2) ? 16'($urandom) : 16'($urandom % 8);
      cyc(($urandom % 5) != 0, o, pick_data(int'($urandom % 13)));
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule